// File: doc/BRIEF.md
# Converter Safety Enable and Sample Watchdog

This block guards the run enable of a two-phase boost/buck converter controller. The controller may run only while a software enable bit and an external hardware enable input are both high and the fault input is low. A small register write/read port carries the control bit, the watchdog period and the three feedback samples the control loop consumes: DC-link voltage and the inductor current of each switching phase.

A watchdog checks that feedback stays fresh. A sample set counts as fresh once all three feedback registers have been written since the last reload. If no fresh set arrives within the programmed number of clocks, the software enable drops and a sticky timeout flag is set. A fault input drops the software enable at once and latches a fault flag. While the fault input stays high, software cannot set the enable again. A phase-select output alternates between the two switching phases, which run half a period apart, and only while the converter is enabled.

Top module: `cnv_guard`

## Requirements
- R1: `conv_en` is high exactly when the software enable bit, `hw_en` and the inverted `fault_in` are all high; `fault_in` forces it low in the same cycle.
- R2: After reset the software enable, both sticky flags, the timeout period, all sample registers, `conv_en` and `phase_sel` are zero.
- R3: A write to address 0 with data bit 0 set, while `fault_in` is low, sets the software enable and clears both sticky flags. A write with bit 0 clear clears the enable. Address 0 reads the enable in bit 0.
- R4: While `fault_in` is high, the next clock edge clears the software enable and sets the latched fault flag.
- R5: A write to address 0 with bit 0 set while `fault_in` is high has no effect: the enable stays clear and the flags are kept.
- R6: Addresses 2 (DC-link voltage), 3 (phase A current) and 4 (phase B current) hold the written 16-bit samples, and address 1 holds the 16-bit timeout period. Each reads back the last value written.
- R7: The watchdog reloads only when all three sample registers have been written since the last reload. Writing the last missing one reloads it. Accepting an enable write also reloads it and forgets earlier sample writes.
- R8: With a nonzero period T and the enable set, if there is no reload, the clock edge T+1 cycles after the last reload clears the enable and sets the timeout flag.
- R9: A period of zero disables the watchdog: the enable stays set indefinitely without samples.
- R10: The timeout flag stays set until an accepted enable write. Running again needs such a write.
- R11: While `conv_en` is high, `phase_sel` toggles every HALF_CYC clocks, starting at 0. The first toggle comes HALF_CYC edges after the enable is taken. While `conv_en` is low, `phase_sel` returns to 0 on the next edge.
- R12: Address 5 reads status: bit 0 `conv_en`, bit 1 `fault_in` level, bit 2 latched fault, bit 3 timeout flag. Writes to address 5 and reads of addresses 6 and 7 have no effect and return zero. `stat_fault` and `stat_timeout` mirror the two flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| hw_en | input | 1 | External hardware enable |
| fault_in | input | 1 | Fault input, active high |
| conv_en | output | 1 | Gated converter enable |
| phase_sel | output | 1 | Active switching phase, 0 = A, 1 = B |
| stat_fault | output | 1 | Latched fault flag |
| stat_timeout | output | 1 | Sticky watchdog timeout flag |

## Verification
The bench sweeps the watchdog period over small values and checks the enable on the last cycle before expiry and on the expiry cycle itself. An off-by-one counter therefore fails on one side or the other. It walks every non-empty subset of the three sample writes after an enable write. A design that reloaded on any single sample, or that remembered writes from before the re-arm, would keep running when it should stop. It also tries to re-arm while the fault input is held high, where a wrong design would restart a faulted converter. It checks the timing of the phase toggle, its start value of zero, and its return to zero when the enable drops.

// File: rtl/cnv_guard_pkg.sv
package cnv_guard_pkg;
  localparam int NUM_SMP = 3;

  typedef enum logic [2:0] {
    ADR_CTRL = 3'd0,
    ADR_TMO  = 3'd1,
    ADR_VBUS = 3'd2,
    ADR_IA   = 3'd3,
    ADR_IB   = 3'd4,
    ADR_STAT = 3'd5
  } reg_addr_e;

  localparam logic [2:0] SMP_BASE = 3'd2;

  localparam int ST_EN  = 0;
  localparam int ST_FIN = 1;
  localparam int ST_FLT = 2;
  localparam int ST_TMO = 3;
endpackage

// File: rtl/cnv_guard_regs.sv
module cnv_guard_regs
  import cnv_guard_pkg::*;
#(
  parameter int DW = 16,
  parameter int TW = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [2:0]            wr_addr,
  input  logic [DW-1:0]         wr_data,
  input  logic                  fault_in,
  input  logic                  expire,
  output logic                  sw_en,
  output logic                  fault_flag,
  output logic                  tmo_flag,
  output logic                  arm_ok,
  output logic [TW-1:0]         tmo_val,
  output logic [NUM_SMP-1:0]    smp_wr,
  output logic [NUM_SMP*DW-1:0] smp_flat
);
  logic          ctrl_wr, tmo_wr;
  logic          sw_en_d, fault_flag_d, tmo_flag_d;
  logic [TW-1:0] tmo_d;

  assign ctrl_wr = wr_en && (wr_addr == ADR_CTRL);
  assign tmo_wr  = wr_en && (wr_addr == ADR_TMO);
  assign arm_ok  = ctrl_wr && wr_data[0] && !fault_in;

  always_comb begin
    sw_en_d      = sw_en;
    fault_flag_d = fault_flag;
    tmo_flag_d   = tmo_flag;
    if (fault_in) begin
      sw_en_d      = 1'b0;
      fault_flag_d = 1'b1;
    end else if (arm_ok) begin
      sw_en_d      = 1'b1;
      fault_flag_d = 1'b0;
      tmo_flag_d   = 1'b0;
    end else if (expire) begin
      sw_en_d    = 1'b0;
      tmo_flag_d = 1'b1;
    end else if (ctrl_wr) begin
      sw_en_d = 1'b0;
    end
    tmo_d = tmo_wr ? wr_data[TW-1:0] : tmo_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_en      <= 1'b0;
      fault_flag <= 1'b0;
      tmo_flag   <= 1'b0;
      tmo_val    <= '0;
    end else begin
      sw_en      <= sw_en_d;
      fault_flag <= fault_flag_d;
      tmo_flag   <= tmo_flag_d;
      tmo_val    <= tmo_d;
    end
  end

  for (genvar i = 0; i < NUM_SMP; i++) begin : g_smp
    logic [DW-1:0] smp_q, smp_d;
    assign smp_wr[i] = wr_en && (wr_addr == SMP_BASE + 3'(i));
    always_comb smp_d = smp_wr[i] ? wr_data : smp_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) smp_q <= '0;
      else        smp_q <= smp_d;
    end
    assign smp_flat[i*DW +: DW] = smp_q;
  end
endmodule

// File: rtl/cnv_guard_wdog.sv
module cnv_guard_wdog
  import cnv_guard_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SMP-1:0] smp_wr,
  input  logic               rearm,
  input  logic               running,
  input  logic [TW-1:0]      tmo_val,
  output logic               expire
);
  logic [NUM_SMP-1:0] seen_q, seen_d, seen_all;
  logic [TW-1:0]      cnt_q, cnt_d;
  logic               reload, armed;

  assign seen_all = seen_q | smp_wr;
  assign reload   = (&seen_all) && (|smp_wr);
  assign armed    = running && (tmo_val != '0);
  assign expire   = armed && (cnt_q == '0) && !reload && !rearm;

  always_comb begin
    seen_d = seen_all;
    cnt_d  = cnt_q;
    if (rearm || reload) begin
      seen_d = '0;
      cnt_d  = tmo_val;
    end else if (armed && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      cnt_q  <= '0;
    end else begin
      seen_q <= seen_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/cnv_guard_phase.sv
module cnv_guard_phase #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic phase_sel
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ph_d;

  always_comb begin
    cnt_d = '0;
    ph_d  = 1'b0;
    if (run) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        ph_d  = ~phase_sel;
      end else begin
        cnt_d = cnt_q + 1'b1;
        ph_d  = phase_sel;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      phase_sel <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      phase_sel <= ph_d;
    end
  end
endmodule

// File: rtl/cnv_guard.sv
module cnv_guard
  import cnv_guard_pkg::*;
#(
  parameter int DW       = 16,
  parameter int TW       = 16,
  parameter int HALF_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          hw_en,
  input  logic          fault_in,
  output logic          conv_en,
  output logic          phase_sel,
  output logic          stat_fault,
  output logic          stat_timeout
);
  logic [1:0]            rst_pipe;
  logic                  rst_q;
  logic                  sw_en, fault_flag, tmo_flag, arm_ok, expire;
  logic [TW-1:0]         tmo_val;
  logic [NUM_SMP-1:0]    smp_wr;
  logic [NUM_SMP*DW-1:0] smp_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  cnv_guard_regs #(.DW(DW), .TW(TW)) u_regs (
    .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fault_in(fault_in), .expire(expire),
    .sw_en(sw_en), .fault_flag(fault_flag), .tmo_flag(tmo_flag),
    .arm_ok(arm_ok), .tmo_val(tmo_val), .smp_wr(smp_wr), .smp_flat(smp_flat)
  );

  cnv_guard_wdog #(.TW(TW)) u_wdog (
    .clk(clk), .rst_n(rst_q), .smp_wr(smp_wr), .rearm(arm_ok),
    .running(sw_en), .tmo_val(tmo_val), .expire(expire)
  );

  assign conv_en = sw_en && hw_en && !fault_in;

  cnv_guard_phase #(.HALF_CYC(HALF_CYC)) u_phase (
    .clk(clk), .rst_n(rst_q), .run(conv_en), .phase_sel(phase_sel)
  );

  assign stat_fault   = fault_flag;
  assign stat_timeout = tmo_flag;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADR_CTRL: rd_data[0] = sw_en;
      ADR_TMO:  rd_data[TW-1:0] = tmo_val;
      ADR_VBUS: rd_data = smp_flat[0*DW +: DW];
      ADR_IA:   rd_data = smp_flat[1*DW +: DW];
      ADR_IB:   rd_data = smp_flat[2*DW +: DW];
      ADR_STAT: begin
        rd_data[ST_EN]  = conv_en;
        rd_data[ST_FIN] = fault_in;
        rd_data[ST_FLT] = fault_flag;
        rd_data[ST_TMO] = tmo_flag;
      end
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cnv_guard_chk.sv
module cnv_guard_chk #(
  parameter int DW = 16,
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          fault_in,
  input logic          sw_en,
  input logic          fault_flag,
  input logic          tmo_flag,
  input logic          expire,
  input logic [TW-1:0] tmo_val,
  input logic          conv_en,
  input logic          phase_sel
);
  logic arm_try;
  assign arm_try = wr_en && (wr_addr == 3'd0) && wr_data[0];

  AST_FAULT_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    fault_in |=> (!sw_en && fault_flag)); // R4

  AST_NO_ARM_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_try && fault_in) |=> !sw_en); // R5

  AST_EXPIRE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (!sw_en && tmo_flag)); // R8

  AST_ZERO_PERIOD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_val == '0) |-> !expire); // R9

  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !(arm_try && !fault_in)) |=> tmo_flag); // R10

  AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_en |=> !phase_sel); // R11
endmodule

bind cnv_guard cnv_guard_chk #(.DW(DW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .fault_in(fault_in), .sw_en(sw_en),
  .fault_flag(fault_flag), .tmo_flag(tmo_flag), .expire(expire),
  .tmo_val(tmo_val), .conv_en(conv_en), .phase_sel(phase_sel)
);

// File: tb/cnv_guard_test.sv
module cnv_guard_test;
  localparam int HALF = 4;

  logic        clk, rst_n, wr_en, hw_en, fault_in;
  logic [2:0]  wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  logic        conv_en, phase_sel, stat_fault, stat_timeout;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] v;

  cnv_guard #(.DW(16), .TW(16), .HALF_CYC(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .hw_en(hw_en), .fault_in(fault_in), .conv_en(conv_en),
    .phase_sel(phase_sel), .stat_fault(stat_fault), .stat_timeout(stat_timeout)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Caller is at a negedge; the write takes the next rising edge.
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; hw_en = 1'b0; fault_in = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R2 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk($sformatf("R2 reset addr %0d", a), v, 16'h0);
    end
    chk("R2 reset conv_en/phase", {14'h0, conv_en, phase_sel}, 16'h0);

    // R6 sample and period readback, patterns
    for (int p = 0; p < 4; p++) begin
      logic [15:0] pat;
      pat = 16'hA5C3 ^ 16'(p * 16'h1111) ^ (p[0] ? 16'hFFFF : 16'h0);
      for (int a = 1; a < 5; a++) wr(3'(a), pat + 16'(a));
      for (int a = 1; a < 5; a++) begin
        rd(3'(a), v);
        chk($sformatf("R6 readback addr %0d", a), v, pat + 16'(a));
      end
    end

    // R12 unmapped reads, status write ignored
    wr(3'd5, 16'hFFFF);
    rd(3'd5, v); chk("R12 status write ignored", v, 16'h0);
    rd(3'd6, v); chk("R12 addr6 zero", v, 16'h0);
    rd(3'd7, v); chk("R12 addr7 zero", v, 16'h0);

    // R1 / R3 enable gating sweep, watchdog off (R9)
    wr(3'd1, 16'd0);
    for (int h = 0; h < 2; h++)
      for (int s = 0; s < 2; s++) begin
        hw_en = h[0];
        wr(3'd0, {15'h0, s[0]});
        #1;
        chk($sformatf("R1 gate hw=%0d sw=%0d", h, s), {15'h0, conv_en}, {15'h0, h[0] & s[0]});
        rd(3'd0, v);
        chk("R3 ctrl readback", v, {15'h0, s[0]});
        rd(3'd5, v);
        chk("R12 status en bit", v, {15'h0, h[0] & s[0]});
      end

    // R9 zero period: stays enabled
    hw_en = 1'b1;
    wr(3'd0, 16'h1);
    idle(60);
    chk("R9 zero period keeps enable", {15'h0, conv_en}, 16'h1);

    // R11 phase select timing
    wr(3'd0, 16'h0);
    idle(2);
    wr(3'd0, 16'h1);
    idle(HALF - 1);
    chk("R11 phase before first toggle", {15'h0, phase_sel}, 16'h0);
    idle(1);
    chk("R11 phase first toggle", {15'h0, phase_sel}, 16'h1);
    idle(HALF);
    chk("R11 phase second toggle", {15'h0, phase_sel}, 16'h0);
    idle(HALF);
    chk("R11 phase third toggle", {15'h0, phase_sel}, 16'h1);
    hw_en = 1'b0;
    idle(1);
    chk("R11 phase idle low", {15'h0, phase_sel}, 16'h0);
    hw_en = 1'b1;

    // R8 expiry timing sweep
    for (int t = 1; t <= 6; t++) begin
      wr(3'd1, 16'(t));
      wr(3'd0, 16'h1);
      idle(t);
      chk($sformatf("R8 T=%0d still on", t), {15'h0, conv_en}, 16'h1);
      idle(1);
      chk($sformatf("R8 T=%0d expired", t), {15'h0, conv_en}, 16'h0);
      rd(3'd5, v);
      chk($sformatf("R8 T=%0d status", t), v, 16'h0008);
      // R10 sticky until accepted enable write
      idle(5);
      chk("R10 timeout sticky", {15'h0, stat_timeout}, 16'h1);
      rd(3'd0, v);
      chk("R10 enable stays clear", v, 16'h0);
    end

    // R7 sample subsets after re-arm, period 6
    wr(3'd1, 16'd6);
    for (int m = 1; m < 8; m++) begin
      wr(3'd0, 16'h1);
      chk("R10 re-arm clears timeout", {15'h0, stat_timeout}, 16'h0);
      for (int b = 0; b < 3; b++)
        if (m[b]) wr(3'(2 + b), 16'(m * 7 + b));
      idle(6);
      chk($sformatf("R7 mask %0d before deadline", m), {15'h0, conv_en}, {15'h0, m == 7});
      idle(1);
      chk($sformatf("R7 mask %0d after deadline", m), {15'h0, conv_en}, 16'h0);
    end

    // R7 periodic full sets keep it alive
    wr(3'd0, 16'h1);
    for (int k = 0; k < 10; k++) begin
      wr(3'd2, 16'(k)); wr(3'd3, 16'(k)); wr(3'd4, 16'(k));
      idle(3);
    end
    chk("R7 refreshed stays on", {15'h0, conv_en}, 16'h1);

    // R4 / R5 fault handling
    wr(3'd1, 16'd0);
    wr(3'd0, 16'h1);
    fault_in = 1'b1;
    #1;
    chk("R1 fault forces conv_en low", {15'h0, conv_en}, 16'h0);
    @(negedge clk);
    rd(3'd5, v);
    chk("R4 fault status", v, 16'h0006);
    rd(3'd0, v);
    chk("R4 enable cleared", v, 16'h0);
    wr(3'd0, 16'h1);
    rd(3'd0, v);
    chk("R5 arm ignored in fault", v, 16'h0);
    chk("R5 fault flag kept", {15'h0, stat_fault}, 16'h1);
    fault_in = 1'b0;
    idle(2);
    rd(3'd5, v);
    chk("R4 flag latched after release", v, 16'h0004);
    wr(3'd0, 16'h1);
    rd(3'd5, v);
    chk("R3 re-arm after fault", v, 16'h0001);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule